// File: doc/BRIEF.md
# Interleaved Round-Robin Thread Issue Stage

This block is the issue front of a single-issue core that interleaves several hardware threads cycle by cycle. In each clock it picks one eligible thread and issues it. Round-robin order starts at the thread after the one that issued last. A thread is eligible when its enable bit is set and it has no instruction still travelling down the pipeline. Because a thread never has two instructions in flight, the stages behind the issue point need neither forwarding nor interlocks. Each thread keeps a private program counter. A stand-in for the later stages adds 4 to that counter on each issue, and a redirect port can load a new counter value instead.

The issue result is a valid-qualified stream with no back-pressure. `issue_valid` marks a real instruction and a cleared bit marks a bubble. The consumer must accept every cycle, because the pipeline always advances. The block also presents a chain of thread tags, one for each pipeline stage, so that later stages know which thread each slot belongs to. The enable mask and the redirect inputs are plain control pins.

Top module: `barrel_issue`

## Requirements
- R1: After reset no thread is enabled, every stage slot is empty (`issue_valid` and all `stage_valid` bits are 0), and thread t's program counter holds t*256.
- R2: At most one instruction issues per clock edge. The issuing thread is the first eligible thread found when counting upward, with wrap-around, from the last thread that issued. Before any issue after reset the search starts at thread 0.
- R3: A thread has at most one instruction in the pipeline. It becomes eligible again in the cycle its instruction sits in the final stage, so a lone enabled thread issues once every NSTAGE cycles.
- R4: Disabled threads and threads with an instruction in flight are skipped. When no thread is eligible, a bubble with `issue_valid`=0 enters stage 0.
- R5: Stage k+1 holds on each edge the valid bit and thread tag that stage k held before it. Stage k's tag is `stage_tid[k*TW +: TW]`, where TW = log2(NTHREAD). Stage 0 is the issue slot.
- R6: Each issue reports the issuing thread's current counter on `issue_pc`, and that thread's counter then advances by 4. The counters of other threads are unchanged.
- R7: A redirect loads `redir_pc` into thread `redir_tid`'s counter on the edge. When the same thread issues on that edge, the redirect value wins over the +4 step.
- R8: A write of `mask_data` under `mask_wr` changes which threads are enabled starting with the selection made on the following edge. The selection on the write edge uses the old mask.
- R9: Disabling a thread does not remove its instruction from the pipeline. The instruction keeps moving through all stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | Load the thread enable mask |
| mask_data | input | NTHREAD | New enable mask, one bit per thread |
| redir_valid | input | 1 | Redirect request |
| redir_tid | input | TW | Thread whose counter is redirected |
| redir_pc | input | PCW | New counter value |
| issue_valid | output | 1 | Stage 0 holds a real instruction |
| issue_tid | output | TW | Thread of the instruction in stage 0 |
| issue_pc | output | PCW | Counter value issued for that instruction |
| stage_valid | output | NSTAGE | Occupancy of each pipeline stage |
| stage_tid | output | NSTAGE*TW | Thread tag of each stage, stage k at bits k*TW |

## Verification
Two pairs of events can land on the same edge. The first pair is a redirect and an issue of the same thread: the bench redirects a rotating thread on every cycle while all threads run, so the redirect sometimes meets that thread's own issue. The expected counter is then the redirect value, not the +4 step. The second pair is a thread leaving the final stage on the same edge that the selector considers it again: a lone enabled thread has to reissue exactly on its drain edge. The bench also sweeps all 256 enable masks against a reference model that uses the old-mask-on-write-edge rule.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  localparam int unsigned PC_STEP    = 4;
  localparam int unsigned BASE_SHIFT = 8;

  function automatic logic [31:0] base_pc(input int unsigned tid);
    return 32'(tid) << BASE_SHIFT;
  endfunction
endpackage

// File: rtl/barrel_rr_pick.sv
module barrel_rr_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned TW = 3
) (
  input  logic [N-1:0]  elig,
  input  logic [TW-1:0] last,
  output logic          found,
  output logic [TW-1:0] sel
);
  always_comb begin
    found = 1'b0;
    sel   = last;
    for (int k = 1; k <= int'(N); k++) begin
      if (!found && elig[(int'(last) + k) % int'(N)]) begin
        found = 1'b1;
        sel   = TW'((int'(last) + k) % int'(N));
      end
    end
  end
endmodule

// File: rtl/barrel_pc_bank.sv
module barrel_pc_bank
  import barrel_pkg::*;
#(
  parameter int unsigned N   = 8,
  parameter int unsigned TW  = 3,
  parameter int unsigned PCW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [TW-1:0]     adv_tid,
  input  logic              ld_en,
  input  logic [TW-1:0]     ld_tid,
  input  logic [PCW-1:0]    ld_pc,
  output logic [N*PCW-1:0]  pc_flat
);
  for (genvar t = 0; t < int'(N); t++) begin : g_thr
    logic [PCW-1:0] pc_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        pc_q <= PCW'(base_pc(t));
      else if (ld_en && ld_tid == TW'(t))
        pc_q <= ld_pc;
      else if (adv_en && adv_tid == TW'(t))
        pc_q <= pc_q + PCW'(PC_STEP);
    end
    assign pc_flat[t*PCW +: PCW] = pc_q;
  end
endmodule

// File: rtl/barrel_tag_pipe.sv
module barrel_tag_pipe #(
  parameter int unsigned S   = 4,
  parameter int unsigned TW  = 3,
  parameter int unsigned PCW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [TW-1:0]    in_tid,
  input  logic [PCW-1:0]   in_pc,
  output logic [S-1:0]     v,
  output logic [S*TW-1:0]  tid_flat,
  output logic [PCW-1:0]   head_pc
);
  logic [TW-1:0] tid_q [S];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v       <= '0;
      head_pc <= '0;
    end else begin
      v       <= {v[S-2:0], in_v};
      head_pc <= in_pc;
    end
  end

  for (genvar k = 0; k < int'(S); k++) begin : g_stg
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) tid_q[0] <= '0;
        else        tid_q[0] <= in_tid;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) tid_q[k] <= '0;
        else        tid_q[k] <= tid_q[k-1];
      end
    end
    assign tid_flat[k*TW +: TW] = tid_q[k];
  end
endmodule

// File: rtl/barrel_issue.sv
module barrel_issue #(
  parameter int unsigned NTHREAD = 8,
  parameter int unsigned NSTAGE  = 4,
  parameter int unsigned PCW     = 32,
  localparam int unsigned TW     = $clog2(NTHREAD)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mask_wr,
  input  logic [NTHREAD-1:0]   mask_data,
  input  logic                 redir_valid,
  input  logic [TW-1:0]        redir_tid,
  input  logic [PCW-1:0]       redir_pc,
  output logic                 issue_valid,
  output logic [TW-1:0]        issue_tid,
  output logic [PCW-1:0]       issue_pc,
  output logic [NSTAGE-1:0]    stage_valid,
  output logic [NSTAGE*TW-1:0] stage_tid
);
  logic [NTHREAD-1:0]     act_q, infl_q, leave_oh, issue_oh, elig;
  logic [TW-1:0]          last_q, sel;
  logic                   found;
  logic [NTHREAD*PCW-1:0] pc_flat;
  logic [PCW-1:0]         sel_pc;

  // a thread in the final stage leaves on this edge and may be picked again
  always_comb begin
    leave_oh = '0;
    if (stage_valid[NSTAGE-1])
      leave_oh[stage_tid[(NSTAGE-1)*TW +: TW]] = 1'b1;
    issue_oh = '0;
    if (found) issue_oh[sel] = 1'b1;
  end

  assign elig   = act_q & ~(infl_q & ~leave_oh);
  assign sel_pc = pc_flat[sel*PCW +: PCW];

  barrel_rr_pick #(.N(NTHREAD), .TW(TW)) u_pick (
    .elig (elig),
    .last (last_q),
    .found(found),
    .sel  (sel)
  );

  barrel_pc_bank #(.N(NTHREAD), .TW(TW), .PCW(PCW)) u_pcs (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (found),
    .adv_tid(sel),
    .ld_en  (redir_valid),
    .ld_tid (redir_tid),
    .ld_pc  (redir_pc),
    .pc_flat(pc_flat)
  );

  barrel_tag_pipe #(.S(NSTAGE), .TW(TW), .PCW(PCW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (found),
    .in_tid  (sel),
    .in_pc   (sel_pc),
    .v       (stage_valid),
    .tid_flat(stage_tid),
    .head_pc (issue_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= '0;
      infl_q <= '0;
      last_q <= TW'(NTHREAD - 1);
    end else begin
      if (mask_wr) act_q <= mask_data;
      infl_q <= (infl_q & ~leave_oh) | issue_oh;
      if (found) last_q <= sel;
    end
  end

  assign issue_valid = stage_valid[0];
  assign issue_tid   = stage_tid[TW-1:0];
endmodule

// File: rtl/barrel_issue_chk.sv
module barrel_issue_chk #(
  parameter int unsigned NTHREAD = 8,
  parameter int unsigned NSTAGE  = 4,
  parameter int unsigned TW      = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NTHREAD-1:0]   act_q,
  input logic [NTHREAD-1:0]   infl_q,
  input logic                 issue_valid,
  input logic [TW-1:0]        issue_tid,
  input logic [NSTAGE-1:0]    stage_valid,
  input logic [NSTAGE*TW-1:0] stage_tid
);
  logic [NTHREAD-1:0] act_d;
  always_ff @(posedge clk) begin
    if (!rst_n) act_d <= '0;
    else        act_d <= act_q;
  end

  // R3: flags and pipeline occupancy agree
  assert_infl_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(infl_q) == $countones(stage_valid));

  // R3: no two occupied stages carry the same thread
  always @(posedge clk) begin
    if (rst_n) begin
      for (int a = 0; a < int'(NSTAGE); a++)
        for (int b = a + 1; b < int'(NSTAGE); b++)
          assert_distinct_R3: assert (!(stage_valid[a] && stage_valid[b] &&
            stage_tid[a*TW +: TW] == stage_tid[b*TW +: TW]));
    end
  end

  // R4: only an enabled thread enters stage 0
  assert_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> act_d[issue_tid]);

  // R4: empty mask yields a bubble
  assert_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |=> !issue_valid);

  // R5: tags advance one stage per edge
  for (genvar k = 0; k + 1 < int'(NSTAGE); k++) begin : g_sh
    assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stage_valid[k+1] == $past(stage_valid[k]) &&
      (!stage_valid[k+1] || stage_tid[(k+1)*TW +: TW] == $past(stage_tid[k*TW +: TW])));
  end
endmodule

bind barrel_issue barrel_issue_chk #(.NTHREAD(NTHREAD), .NSTAGE(NSTAGE), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .act_q      (act_q),
  .infl_q     (infl_q),
  .issue_valid(issue_valid),
  .issue_tid  (issue_tid),
  .stage_valid(stage_valid),
  .stage_tid  (stage_tid)
);

// File: tb/barrel_issue_test.sv
`timescale 1ns/1ps
module barrel_issue_test;
  localparam int N = 8, S = 4, PCW = 32, TW = 3;

  logic clk = 0, rst_n = 0;
  logic mask_wr = 0;
  logic [N-1:0] mask_data = '0;
  logic redir_valid = 0;
  logic [TW-1:0] redir_tid = '0;
  logic [PCW-1:0] redir_pc = '0;
  logic issue_valid;
  logic [TW-1:0] issue_tid;
  logic [PCW-1:0] issue_pc;
  logic [S-1:0] stage_valid;
  logic [S*TW-1:0] stage_tid;

  always #2 clk = ~clk;

  barrel_issue #(.NTHREAD(N), .NSTAGE(S), .PCW(PCW)) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [N-1:0] m_act, m_inf;
  int m_last;
  logic [PCW-1:0] m_pc [N];
  logic [PCW-1:0] m_ipc;
  logic m_sv [S];
  int m_st [S];

  task automatic model_reset();
    m_act = '0; m_inf = '0; m_last = N - 1; m_ipc = '0;
    for (int t = 0; t < N; t++) m_pc[t] = PCW'(t * 256);
    for (int k = 0; k < S; k++) begin m_sv[k] = 0; m_st[k] = 0; end
  endtask

  task automatic compare(string req);
    bit ok = 1;
    checks++;
    if (issue_valid !== m_sv[0]) ok = 0;
    if (m_sv[0] && (issue_tid !== TW'(m_st[0]) || issue_pc !== m_ipc)) ok = 0;
    for (int k = 0; k < S; k++) begin
      if (stage_valid[k] !== m_sv[k]) ok = 0;
      if (m_sv[k] && stage_tid[k*TW +: TW] !== TW'(m_st[k])) ok = 0;
    end
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d: actual v=%b tid=%0d pc=%h sv=%b st=%h ; expected v=%b tid=%0d pc=%h sv=%b%b%b%b",
        req, cyc, issue_valid, issue_tid, issue_pc, stage_valid, stage_tid,
        m_sv[0], m_st[0], m_ipc, m_sv[3], m_sv[2], m_sv[1], m_sv[0]);
    end
  endtask

  // one edge: predict, clock, compare
  task automatic tick(string req);
    int leave = -1, sel = 0;
    bit found = 0;
    if (m_sv[S-1]) leave = m_st[S-1];
    for (int k = 1; k <= N; k++) begin
      int t = (m_last + k) % N;
      if (!found && m_act[t] && !(m_inf[t] && t != leave)) begin found = 1; sel = t; end
    end
    for (int k = S - 1; k > 0; k--) begin m_sv[k] = m_sv[k-1]; m_st[k] = m_st[k-1]; end
    m_sv[0] = found; m_st[0] = sel;
    if (found) m_ipc = m_pc[sel];
    if (leave >= 0) m_inf[leave] = 1'b0;
    if (found) begin m_inf[sel] = 1'b1; m_last = sel; m_pc[sel] = m_pc[sel] + 4; end
    if (redir_valid) m_pc[redir_tid] = redir_pc;
    if (mask_wr) m_act = mask_data;
    @(posedge clk); #1; cyc++;
    mask_wr = 0; redir_valid = 0;
    compare(req);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    compare("R1");
    tick("R1");
    // R1/R2/R5/R6: all threads, check base counters and rotation
    mask_wr = 1; mask_data = 8'hFF; tick("R8");
    repeat (40) tick("R2");
    // R3: lone thread reissues on its drain edge
    mask_wr = 1; mask_data = 8'h01; tick("R8");
    repeat (16) tick("R3");
    // R4/R8: sweep every mask
    for (int m = 0; m < 256; m++) begin
      mask_wr = 1; mask_data = N'(m); tick("R8");
      repeat (6) tick("R4");
    end
    // R7: rotating redirects colliding with issues
    mask_wr = 1; mask_data = 8'hFF; tick("R8");
    for (int c = 0; c < 24; c++) begin
      redir_valid = 1; redir_tid = TW'(c % N); redir_pc = PCW'(32'h1000 + c * 16);
      tick("R7");
    end
    repeat (10) tick("R6");
    // R9: clear all enables while instructions are in flight
    mask_wr = 1; mask_data = 8'h00; tick("R9");
    repeat (6) tick("R9");
    // R4: partial mask with wrap-around
    mask_wr = 1; mask_data = 8'b1000_0010; tick("R8");
    repeat (12) tick("R4");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule